// File: doc/BRIEF.md
# Saturating Cache Event Counter Unit

This block gives a cache controller two identical 32-bit event counters. Each counter has a configuration register. Its source field picks one of fifteen one-cycle event pulses coming from the cache pipeline, and its interrupt-mode field is stored and read back but drives nothing. A shared control register holds a single count-enable bit that starts and stops both counters together. Software reads and writes every register through a plain single-cycle register port. Writes take effect at the clock edge, and reads return the current register contents combinationally.

A counter does not wrap. Once it reaches all-ones it stays there, and events that arrive after that point are lost. Software is expected to stop counting with the enable bit, read both values, load them back to zero and restart. The per-counter registers sit in descending address order: the register for counter k is 4 bytes below the one for counter k-1.

The count gate is a two-state machine. In `GS_HALT` nothing counts, and in `GS_RUN` counting is allowed. Writing the control register with bit 0 set takes the *start* transition from `GS_HALT` to `GS_RUN`. Writing it with bit 0 clear takes the *halt* transition from `GS_RUN` to `GS_HALT`. Any other control write leaves the state unchanged. Reset enters `GS_HALT`.

Top module: `sat_evt_monitor`

## Requirements
- R1: After reset every mapped register reads 0: both counters, both configurations (source 0), and the control register (enable clear, state `GS_HALT`).
- R2: Register map, by byte offset. The control register is at 0x00, with the enable in bit 0. The configuration of counter k is at 0x0C − 4·k, with the source code in bits [5:2] and the interrupt mode in bits [1:0]. The value of counter k is at 0x14 − 4·k. Any other offset reads 0.
- R3: When the enable is set and a counter's source code c is nonzero, the counter adds 1 at each clock edge where event input bit c−1 is high.
- R4: A counter at 0xFFFFFFFF stays at 0xFFFFFFFF when further selected events arrive.
- R5: While the enable bit is clear, neither counter changes, whatever the event inputs are.
- R6: A counter whose source code is 0 does not count.
- R7: A write to a value register in the same cycle as a counted event loads the written data, and the event is dropped.
- R8: When several event bits are high in one cycle, each counter adds at most 1, and only for its own selected event.
- R9: With the parameter `EXT_EVENTS` at 0, source codes 0xA to 0xF never count. Codes 0x1 to 0x9 behave as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe for this cycle |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr`, combinational |
| evt_pulse | input | NUM_EVT (15) | Event pulses; bit c−1 belongs to source code c |

## Verification
A register write or a counted event changes the stored state at the clock edge where it is sampled. Read data is combinational, so the new value appears in the same cycle that follows that edge.

The bench drives each vector shortly after a falling edge. It checks the read data 1 ns later, which is before the next rising edge. At that point the read shows the effect of every earlier edge and none of the current vector's own write or events. The expected values in the table are therefore lagged by exactly one row.

The start and halt transitions of the gate behave the same way: the first edge after the control write is the first one that counts, or the first one that does not.

// File: rtl/sevm_pkg.sv
package sevm_pkg;
    localparam int SRC_W    = 4;
    localparam int MODE_W   = 2;
    localparam int CFG_W    = SRC_W + MODE_W;
    localparam int SRC_LSB  = MODE_W;

    typedef enum logic [0:0] {
        GS_HALT = 1'b0,
        GS_RUN  = 1'b1
    } gate_state_t;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [MODE_W-1:0] irq_mode;
    } lane_cfg_t;
endpackage

// File: rtl/evt_select.sv
module evt_select
    import sevm_pkg::*;
#(
    parameter int NUM_EVT    = 15,
    parameter int BASE_EVT   = 9,
    parameter bit EXT_EVENTS = 1'b1
) (
    input  logic [SRC_W-1:0]   src,
    input  logic [NUM_EVT-1:0] evt,
    output logic               hit
);
    localparam int NCODE = 1 << SRC_W;

    logic [NCODE-1:0] avail;

    assign avail[0] = 1'b0;

    for (genvar c = 1; c < NCODE; c++) begin : g_code
        if (c <= NUM_EVT && (c <= BASE_EVT || EXT_EVENTS)) begin : g_live
            assign avail[c] = evt[c-1];
        end else begin : g_tied
            assign avail[c] = 1'b0;
        end
    end

    assign hit = avail[src];
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import sevm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic run
);
    gate_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_HALT: if (ctrl_wr && ctrl_bit)  state_d = GS_RUN;
            GS_RUN:  if (ctrl_wr && !ctrl_bit) state_d = GS_HALT;
            default: state_d = GS_HALT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            GS_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    // R5: the gate follows the last control write
    p_gate_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (run == $past(ctrl_bit)));
endmodule

// File: rtl/sat_lane.sv
module sat_lane #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic             wr_val,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (wr_val)                     cnt <= wdata;
        else if (en && hit && cnt != TOP)    cnt <= cnt + 1'b1;
    end

    p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !wr_val) |=> (cnt == TOP));

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_val) |=> $stable(cnt));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val |=> (cnt == $past(wdata)));

    p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_val |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));
endmodule

// File: rtl/sat_evt_monitor.sv
module sat_evt_monitor
    import sevm_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 8,
    parameter int NUM_CTR    = 2,
    parameter int NUM_EVT    = 15,
    parameter int BASE_EVT   = 9,
    parameter bit EXT_EVENTS = 1'b1,
    parameter int CTRL_OFS   = 'h00,
    parameter int CFG_HI_OFS = 'h0C,
    parameter int VAL_HI_OFS = 'h14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    logic             run;
    logic             ctrl_hit;
    lane_cfg_t        cfg_q [NUM_CTR];
    logic [CNT_W-1:0] cnt   [NUM_CTR];

    assign ctrl_hit = (bus_addr == CTRL_A);

    gate_fsm u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (bus_wr && ctrl_hit),
        .ctrl_bit (bus_wdata[0]),
        .run      (run)
    );

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_lane
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_HI_OFS - 4 * k);
        localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(VAL_HI_OFS - 4 * k);

        logic hit;
        logic wr_val;

        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[k] <= '0;
            else if (bus_wr && bus_addr == CFG_A)
                cfg_q[k] <= lane_cfg_t'(bus_wdata[CFG_W-1:0]);
        end

        assign wr_val = bus_wr && (bus_addr == VAL_A);

        evt_select #(
            .NUM_EVT    (NUM_EVT),
            .BASE_EVT   (BASE_EVT),
            .EXT_EVENTS (EXT_EVENTS)
        ) u_sel (
            .src (cfg_q[k].src),
            .evt (evt_pulse),
            .hit (hit)
        );

        sat_lane #(.CNT_W(CNT_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (run),
            .hit    (hit),
            .wr_val (wr_val),
            .wdata  (bus_wdata),
            .cnt    (cnt[k])
        );

        // R6: a lane with source 0 holds its value
        p_src_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[k].src == '0 && !wr_val) |=> $stable(cnt[k]));

        // R3: an enabled lane with its event high and headroom advances
        p_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !wr_val && cfg_q[k].src == 4'd1 && evt_pulse[0] && cnt[k] != '1)
            |=> (cnt[k] == $past(cnt[k]) + 1'b1));
    end

    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) bus_rdata[0] = run;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (bus_addr == ADDR_W'(CFG_HI_OFS - 4 * k))
                bus_rdata[CFG_W-1:0] = cfg_q[k];
            if (bus_addr == ADDR_W'(VAL_HI_OFS - 4 * k))
                bus_rdata = cnt[k];
        end
    end
endmodule

// File: tb/test_sat_evt_monitor.sv
module test_sat_evt_monitor;
    localparam int NV = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [14:0] evt_pulse = '0;
    logic [31:0] rdata_full, rdata_red;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sat_evt_monitor i_sat_evt_monitor (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_full), .evt_pulse(evt_pulse));

    sat_evt_monitor #(.EXT_EVENTS(1'b0)) i_sat_evt_monitor_red (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_red), .evt_pulse(evt_pulse));

    // {req, wr, addr, data (write data or expected read), events}
    localparam logic [59:0] VEC [NV] = '{
        {4'd1, 1'b0, 8'h00, 32'h0000_0000, 15'h0000},  // R1 ctrl
        {4'd1, 1'b0, 8'h14, 32'h0000_0000, 15'h0000},  // R1 value 0
        {4'd1, 1'b0, 8'h10, 32'h0000_0000, 15'h0000},  // R1 value 1
        {4'd1, 1'b0, 8'h0C, 32'h0000_0000, 15'h0000},  // R1 cfg 0
        {4'd2, 1'b1, 8'h0C, 32'h0000_0009, 15'h0000},  // R2 cfg0 src 2 mode 1
        {4'd2, 1'b1, 8'h08, 32'h0000_002E, 15'h0000},  // R2 cfg1 src B mode 2
        {4'd2, 1'b0, 8'h0C, 32'h0000_0009, 15'h0000},  // R2
        {4'd2, 1'b0, 8'h08, 32'h0000_002E, 15'h0000},  // R2
        {4'd5, 1'b1, 8'h00, 32'h0000_0001, 15'h0000},  // R5 start
        {4'd5, 1'b0, 8'h00, 32'h0000_0001, 15'h0002},  // R5 running; cnt0 -> 1
        {4'd3, 1'b0, 8'h14, 32'h0000_0001, 15'h0402},  // R3; cnt0->2 cnt1->1
        {4'd3, 1'b0, 8'h10, 32'h0000_0001, 15'h7FFF},  // R3; all events
        {4'd8, 1'b0, 8'h14, 32'h0000_0003, 15'h0000},  // R8
        {4'd8, 1'b0, 8'h10, 32'h0000_0002, 15'h0000},  // R8
        {4'd5, 1'b1, 8'h00, 32'h0000_0000, 15'h0000},  // R5 halt
        {4'd5, 1'b0, 8'h14, 32'h0000_0003, 15'h7FFF},  // R5
        {4'd5, 1'b0, 8'h14, 32'h0000_0003, 15'h0000},  // R5 frozen
        {4'd5, 1'b0, 8'h10, 32'h0000_0002, 15'h0000},  // R5 frozen
        {4'd4, 1'b1, 8'h14, 32'hFFFF_FFFE, 15'h0000},  // R4 preload
        {4'd4, 1'b1, 8'h00, 32'h0000_0001, 15'h0000},  // R4 restart
        {4'd4, 1'b0, 8'h14, 32'hFFFF_FFFE, 15'h0002},  // R4
        {4'd4, 1'b0, 8'h14, 32'hFFFF_FFFF, 15'h0002},  // R4 reached top
        {4'd4, 1'b0, 8'h14, 32'hFFFF_FFFF, 15'h0002},  // R4 sticks
        {4'd4, 1'b0, 8'h14, 32'hFFFF_FFFF, 15'h0000},  // R4 sticks
        {4'd7, 1'b1, 8'h14, 32'h0000_0005, 15'h0002},  // R7 write + event
        {4'd7, 1'b0, 8'h14, 32'h0000_0005, 15'h0000},  // R7
        {4'd6, 1'b1, 8'h0C, 32'h0000_0000, 15'h0000},  // R6 src off
        {4'd6, 1'b0, 8'h14, 32'h0000_0005, 15'h7FFF},  // R6; cnt1 -> 3
        {4'd6, 1'b0, 8'h14, 32'h0000_0005, 15'h0000},  // R6
        {4'd8, 1'b0, 8'h10, 32'h0000_0003, 15'h0000},  // R8 own source only
        {4'd2, 1'b0, 8'h04, 32'h0000_0000, 15'h0000}   // R2 unmapped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr    = VEC[i][55];
            bus_addr  = VEC[i][54:47];
            bus_wdata = VEC[i][46:15];
            evt_pulse = VEC[i][14:0];
            #1;
            if (!VEC[i][55])
                check($sformatf("R%0d vec%0d", VEC[i][59:56], i), rdata_full, VEC[i][46:15]);
        end
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
        // R9: reduced variant ignored code B on counter 1, base code 2 on counter 0 matches
        bus_addr = 8'h10; #1;
        check("R9 red cnt1", rdata_red, 32'h0);
        bus_addr = 8'h14; #1;
        check("R9 red cnt0", rdata_red, 32'h5);
        // R2: offset above value registers is unmapped
        bus_addr = 8'h18; #1;
        check("R2 unmapped 0x18", rdata_full, 32'h0);
        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        evt_pulse = 15'h7FFF;
        @(negedge clk);
        rst_n = 1'b1;
        evt_pulse = '0;
        bus_addr = 8'h10; #1;
        check("R1 cnt1 after reset", rdata_full, 32'h0);
        bus_addr = 8'h08; #1;
        check("R1 cfg1 after reset", rdata_full, 32'h0);
        bus_addr = 8'h00; #1;
        check("R1 ctrl after reset", rdata_full, 32'h0);
        finish_run();
    end
endmodule